// File: doc/BRIEF.md
# Double-SHA-256 Proof-of-Work Nonce Search Engine

The engine hunts for a 32-bit nonce that makes a block header's double SHA-256 hash fall below a target. Software supplies three values: the 256-bit chaining state left after compressing the header's first 64 bytes, the 512-bit final message block (the header tail with its padding), and a 256-bit target. For each candidate the engine puts the nonce into the final block and compresses that block starting from the supplied chaining state. It then hashes the resulting 256-bit digest a second time, starting from the standard SHA-256 initial values, and compares the outcome with the target.

One compression round runs per clock. A fixed 12-state sequencer drives a single round datapath through both transforms, the compare and the nonce step. A pulse on `start` captures the inputs. The engine then works unattended until it finds a hash below the target or has tried nonce 0xFFFFFFFF. At that point it raises `done`, with `found` telling the two outcomes apart. The last nonce tried and its hash stay on the outputs until the next `start`.

Top module: `powSearch`

## Requirements
- R1: A `start` pulse while the engine is idle or done captures `midstate`, `block` and `target`. The first candidate nonce is `block[415:384]`, which is message word 3. Words are big-endian: word 0 is `block[511:480]` and word 15 is `block[31:0]`.
- R2: For nonce n the engine forms B, which is `block` with word 3 replaced by n. It computes D = compress(`midstate`, B). The hash is compress(IV, {D, 32'h80000000, 192'b0, 32'd256}), where IV is the standard SHA-256 initial value. The hash is presented with H0 in bits 255:224 and H7 in bits 31:0.
- R3: A candidate is accepted only when the hash, read as an unsigned 256-bit number, is strictly less than `target`. A hash equal to the target is rejected.
- R4: After a rejected candidate the nonce increases by exactly one and a new attempt begins. No other change to the nonce happens during a run.
- R5: On acceptance `done` and `found` both go high. `nonce` and `hash` show the winning pair and all three outputs hold steady until the next `start`.
- R6: If the candidate 0xFFFFFFFF is rejected, the engine stops with `done` high, `found` low and `nonce` equal to 0xFFFFFFFF.
- R7: Counting the clock edge that samples `start` as edge 1, a hit on the k-th candidate (k starting at 1) raises `done` after edge 134·k. Exhausting the nonce space on the k-th candidate raises `done` after edge 134·k+1.
- R8: While a search runs, a `start` pulse and changes on `midstate`, `block` or `target` have no effect on the outcome or its timing.
- R9: After reset, `done` and `found` are low and stay low until a search completes.
- R10: A `start` sampled while `done` is high drops `done` on the following cycle and begins a new search.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a search when idle or done |
| midstate | input | 256 | Chaining state after the header's first block, H0 in the top bits |
| block | input | 512 | Final message block, word 0 in the top bits, nonce in word 3 |
| target | input | 256 | Unsigned threshold the hash must be below |
| done | output | 1 | Search finished (hit or nonce space exhausted) |
| found | output | 1 | High with `done` when a hash below the target was found |
| nonce | output | 32 | Current or final candidate nonce |
| hash | output | 256 | Double hash of the last completed candidate |

## Verification
An error in the round logic, the schedule window, the constant lookup or the initial-value registers changes every bit of the reported hash. Such an error shows up as a hash mismatch against an independent model at the first `done`, 134 cycles after `start`. An error in the sequencer or the round counter moves `done` away from its exact multiple of 134 cycles. A comparator or increment fault gives a winning nonce other than the first candidate below the target. That is why targets are chosen so the winner sits several steps past the start value, and another target equals a candidate's hash exactly.

// File: rtl/powPkg.sv
package powPkg;

  localparam int WORD_W     = 32;
  localparam int ST_WORDS   = 8;
  localparam int BLK_WORDS  = 16;
  localparam int ROUNDS     = 64;
  localparam int RND_W      = $clog2(ROUNDS);
  localparam int SLOT_W     = $clog2(BLK_WORDS);
  localparam int NONCE_SLOT = 3;
  localparam int ST_W       = WORD_W * ST_WORDS;
  localparam int BLK_W      = WORD_W * BLK_WORDS;
  localparam int MSG_BITS   = ST_W;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [3:0] {
    S_IDLE, S_H1_INIT, S_H1_RUN, S_H1_LAST, S_H1_ADD,
    S_H2_INIT, S_H2_RUN, S_H2_LAST, S_H2_ADD,
    S_CMP, S_UPD, S_DONE
  } state_t;

  typedef struct packed {
    logic latchIn;
    logic loadFirst;
    logic loadSecond;
    logic doRound;
    logic addFirst;
    logic addSecond;
    logic bumpNonce;
  } ctl_t;

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t bigSig0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t bigSig1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t smallSig0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t smallSig1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic word_t chooseF(input word_t e, input word_t f, input word_t g);
    return (e & f) ^ (~e & g);
  endfunction

  function automatic word_t majorF(input word_t a, input word_t b, input word_t c);
    return (a & b) ^ (a & c) ^ (b & c);
  endfunction

  function automatic word_t startVal(input logic [2:0] idx);
    case (idx)
      3'd0: return 32'h6a09e667;
      3'd1: return 32'hbb67ae85;
      3'd2: return 32'h3c6ef372;
      3'd3: return 32'ha54ff53a;
      3'd4: return 32'h510e527f;
      3'd5: return 32'h9b05688c;
      3'd6: return 32'h1f83d9ab;
      default: return 32'h5be0cd19;
    endcase
  endfunction

  function automatic word_t roundConst(input logic [RND_W-1:0] idx);
    case (idx)
      6'd0:  return 32'h428a2f98; 6'd1:  return 32'h71374491;
      6'd2:  return 32'hb5c0fbcf; 6'd3:  return 32'he9b5dba5;
      6'd4:  return 32'h3956c25b; 6'd5:  return 32'h59f111f1;
      6'd6:  return 32'h923f82a4; 6'd7:  return 32'hab1c5ed5;
      6'd8:  return 32'hd807aa98; 6'd9:  return 32'h12835b01;
      6'd10: return 32'h243185be; 6'd11: return 32'h550c7dc3;
      6'd12: return 32'h72be5d74; 6'd13: return 32'h80deb1fe;
      6'd14: return 32'h9bdc06a7; 6'd15: return 32'hc19bf174;
      6'd16: return 32'he49b69c1; 6'd17: return 32'hefbe4786;
      6'd18: return 32'h0fc19dc6; 6'd19: return 32'h240ca1cc;
      6'd20: return 32'h2de92c6f; 6'd21: return 32'h4a7484aa;
      6'd22: return 32'h5cb0a9dc; 6'd23: return 32'h76f988da;
      6'd24: return 32'h983e5152; 6'd25: return 32'ha831c66d;
      6'd26: return 32'hb00327c8; 6'd27: return 32'hbf597fc7;
      6'd28: return 32'hc6e00bf3; 6'd29: return 32'hd5a79147;
      6'd30: return 32'h06ca6351; 6'd31: return 32'h14292967;
      6'd32: return 32'h27b70a85; 6'd33: return 32'h2e1b2138;
      6'd34: return 32'h4d2c6dfc; 6'd35: return 32'h53380d13;
      6'd36: return 32'h650a7354; 6'd37: return 32'h766a0abb;
      6'd38: return 32'h81c2c92e; 6'd39: return 32'h92722c85;
      6'd40: return 32'ha2bfe8a1; 6'd41: return 32'ha81a664b;
      6'd42: return 32'hc24b8b70; 6'd43: return 32'hc76c51a3;
      6'd44: return 32'hd192e819; 6'd45: return 32'hd6990624;
      6'd46: return 32'hf40e3585; 6'd47: return 32'h106aa070;
      6'd48: return 32'h19a4c116; 6'd49: return 32'h1e376c08;
      6'd50: return 32'h2748774c; 6'd51: return 32'h34b0bcb5;
      6'd52: return 32'h391c0cb3; 6'd53: return 32'h4ed8aa4a;
      6'd54: return 32'h5b9cca4f; 6'd55: return 32'h682e6ff3;
      6'd56: return 32'h748f82ee; 6'd57: return 32'h78a5636f;
      6'd58: return 32'h84c87814; 6'd59: return 32'h8cc70208;
      6'd60: return 32'h90befffa; 6'd61: return 32'ha4506ceb;
      6'd62: return 32'hbef9a3f7;
      default: return 32'hc67178f2;
    endcase
  endfunction

endpackage

// File: rtl/powControl.sv
module powControl
  import powPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic penult,
  input  logic below,
  input  logic nonceTop,
  output ctl_t ctl,
  output logic done,
  output logic found
);

  state_t state, nxt;
  logic   markHit;

  always_comb begin
    nxt     = state;
    ctl     = '0;
    markHit = 1'b0;
    case (state)
      S_IDLE, S_DONE: begin
        if (start) begin
          ctl.latchIn = 1'b1;
          nxt         = S_H1_INIT;
        end
      end
      S_H1_INIT: begin
        ctl.loadFirst = 1'b1;
        nxt           = S_H1_RUN;
      end
      S_H1_RUN: begin
        ctl.doRound = 1'b1;
        if (penult) nxt = S_H1_LAST;
      end
      S_H1_LAST: begin
        ctl.doRound = 1'b1;
        nxt         = S_H1_ADD;
      end
      S_H1_ADD: begin
        ctl.addFirst = 1'b1;
        nxt          = S_H2_INIT;
      end
      S_H2_INIT: begin
        ctl.loadSecond = 1'b1;
        nxt            = S_H2_RUN;
      end
      S_H2_RUN: begin
        ctl.doRound = 1'b1;
        if (penult) nxt = S_H2_LAST;
      end
      S_H2_LAST: begin
        ctl.doRound = 1'b1;
        nxt         = S_H2_ADD;
      end
      S_H2_ADD: begin
        ctl.addSecond = 1'b1;
        nxt           = S_CMP;
      end
      S_CMP: begin
        if (below) begin
          markHit = 1'b1;
          nxt     = S_DONE;
        end else begin
          nxt = S_UPD;
        end
      end
      S_UPD: begin
        if (nonceTop) begin
          nxt = S_DONE;
        end else begin
          ctl.bumpNonce = 1'b1;
          nxt           = S_H1_INIT;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      found <= 1'b0;
    end else begin
      state <= nxt;
      if (ctl.latchIn) found <= 1'b0;
      else if (markHit) found <= 1'b1;
    end
  end

  assign done = (state == S_DONE);

endmodule

// File: rtl/powDatapath.sv
module powDatapath
  import powPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctl_t             ctl,
  input  logic [ST_W-1:0]  midIn,
  input  logic [BLK_W-1:0] blockIn,
  input  logic [ST_W-1:0]  targetIn,
  output logic [WORD_W-1:0] nonceOut,
  output logic [ST_W-1:0]  hashOut,
  output logic [ST_W-1:0]  targetHeld,
  output logic             penult,
  output logic             below,
  output logic             nonceTop
);

  word_t initA [ST_WORDS];
  word_t initB [ST_WORDS];
  word_t work  [ST_WORDS];
  word_t digA  [ST_WORDS];
  word_t hashW [ST_WORDS];
  word_t blockW[BLK_WORDS];
  word_t sched [BLK_WORDS];
  word_t padW  [BLK_WORDS];
  word_t nonceR;
  logic [ST_W-1:0]  targetR;
  logic [RND_W-1:0] rnd;

  logic [SLOT_W-1:0] slot;
  word_t expandW, wt, t1, t2;

  assign slot = rnd[SLOT_W-1:0];

  // Schedule: a 16-entry circular window, loaded words first, expanded words after.
  always_comb begin
    expandW = smallSig1(sched[slot - SLOT_W'(2)]) + sched[slot - SLOT_W'(7)]
            + smallSig0(sched[slot - SLOT_W'(15)]) + sched[slot];
    wt = (rnd < RND_W'(BLK_WORDS)) ? sched[slot] : expandW;
    t1 = work[7] + bigSig1(work[4]) + chooseF(work[4], work[5], work[6])
       + roundConst(rnd) + wt;
    t2 = bigSig0(work[0]) + majorF(work[0], work[1], work[2]);
  end

  // Second-transform block: digest, a single 1 bit, zeros, bit length.
  always_comb begin
    for (int i = 0; i < BLK_WORDS; i++) begin
      if (i < ST_WORDS)            padW[i] = digA[i];
      else if (i == ST_WORDS)      padW[i] = 32'h8000_0000;
      else if (i == BLK_WORDS - 1) padW[i] = word_t'(MSG_BITS);
      else                         padW[i] = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ST_WORDS; i++) begin
        initA[i] <= '0;
        initB[i] <= '0;
        work[i]  <= '0;
        digA[i]  <= '0;
        hashW[i] <= '0;
      end
      for (int i = 0; i < BLK_WORDS; i++) begin
        blockW[i] <= '0;
        sched[i]  <= '0;
      end
      nonceR  <= '0;
      targetR <= '0;
      rnd     <= '0;
    end else begin
      if (ctl.latchIn) begin
        for (int i = 0; i < ST_WORDS; i++)
          initA[i] <= midIn[ST_W-1-WORD_W*i -: WORD_W];
        for (int i = 0; i < BLK_WORDS; i++)
          blockW[i] <= blockIn[BLK_W-1-WORD_W*i -: WORD_W];
        nonceR  <= blockIn[BLK_W-1-WORD_W*NONCE_SLOT -: WORD_W];
        targetR <= targetIn;
      end
      if (ctl.loadFirst) begin
        for (int i = 0; i < ST_WORDS; i++) work[i] <= initA[i];
        for (int i = 0; i < BLK_WORDS; i++)
          sched[i] <= (i == NONCE_SLOT) ? nonceR : blockW[i];
        rnd <= '0;
      end
      if (ctl.loadSecond) begin
        for (int i = 0; i < ST_WORDS; i++) begin
          work[i]  <= startVal(3'(i));
          initB[i] <= startVal(3'(i));
        end
        for (int i = 0; i < BLK_WORDS; i++) sched[i] <= padW[i];
        rnd <= '0;
      end
      if (ctl.doRound) begin
        work[0] <= t1 + t2;
        work[1] <= work[0];
        work[2] <= work[1];
        work[3] <= work[2];
        work[4] <= work[3] + t1;
        work[5] <= work[4];
        work[6] <= work[5];
        work[7] <= work[6];
        sched[slot] <= wt;
        rnd <= rnd + RND_W'(1);
      end
      if (ctl.addFirst)
        for (int i = 0; i < ST_WORDS; i++) digA[i] <= initA[i] + work[i];
      if (ctl.addSecond)
        for (int i = 0; i < ST_WORDS; i++) hashW[i] <= initB[i] + work[i];
      if (ctl.bumpNonce) nonceR <= nonceR + 32'd1;
    end
  end

  always_comb begin
    for (int i = 0; i < ST_WORDS; i++)
      hashOut[ST_W-1-WORD_W*i -: WORD_W] = hashW[i];
  end

  assign nonceOut   = nonceR;
  assign targetHeld = targetR;
  assign penult     = (rnd == RND_W'(ROUNDS - 2));
  assign below      = (hashOut < targetR);
  assign nonceTop   = &nonceR;

endmodule

// File: rtl/powSearch.sv
module powSearch
  import powPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [255:0] midstate,
  input  logic [511:0] block,
  input  logic [255:0] target,
  output logic         done,
  output logic         found,
  output logic [31:0]  nonce,
  output logic [255:0] hash
);

  ctl_t            ctl;
  logic            penult, below, nonceTop;
  logic [ST_W-1:0] targetHeld;

  powControl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .penult(penult), .below(below), .nonceTop(nonceTop),
    .ctl(ctl), .done(done), .found(found)
  );

  powDatapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .midIn(midstate), .blockIn(block), .targetIn(target),
    .nonceOut(nonce), .hashOut(hash), .targetHeld(targetHeld),
    .penult(penult), .below(below), .nonceTop(nonceTop)
  );

endmodule

// File: rtl/powSearchChk.sv
module powSearchChk (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic [511:0] block,
  input logic         done,
  input logic         found,
  input logic [31:0]  nonce,
  input logic [255:0] hash,
  input logic [255:0] targetHeld
);

  // R5
  found_needs_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    found |-> done);

  // R5
  hold_when_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(nonce) && $stable(hash) && $stable(found)));

  // R10
  restart_drops_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> !done);

  // R1
  nonce_seed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> (nonce == $past(block[415:384])));

  // R4
  nonce_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!done && !start) |=> (nonce == $past(nonce) || nonce == $past(nonce) + 32'd1));

  // R6
  exhaust_nonce_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !found) |-> (nonce == 32'hFFFF_FFFF));

  // R3
  hit_below_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(found) |-> (hash < targetHeld));

endmodule

bind powSearch powSearchChk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .block(block),
  .done(done), .found(found), .nonce(nonce), .hash(hash),
  .targetHeld(targetHeld)
);

// File: tb/powSearch_test.sv
module powSearch_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [255:0] midIn = '0;
  logic [511:0] blkIn = '0;
  logic [255:0] tgtIn = '0;
  logic         done, found;
  logic [31:0]  nonce;
  logic [255:0] hash;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  powSearch uut (
    .clk(clk), .rstN(rstN), .start(start),
    .midstate(midIn), .block(blkIn), .target(tgtIn),
    .done(done), .found(found), .nonce(nonce), .hash(hash)
  );

  localparam logic [255:0] IV =
    256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;

  localparam logic [31:0] KT [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [255:0] refCompress(input logic [255:0] st, input logic [511:0] blk);
    logic [31:0] w [64];
    logic [31:0] a, b, c, d, e, f, g, h, x, y;
    for (int t = 0; t < 16; t++) w[t] = blk[511-32*t -: 32];
    for (int t = 16; t < 64; t++)
      w[t] = (rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10)) + w[t-7]
           + (rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3)) + w[t-16];
    {a, b, c, d, e, f, g, h} = st;
    for (int t = 0; t < 64; t++) begin
      x = h + (rr(e, 6) ^ rr(e, 11) ^ rr(e, 25)) + ((e & f) ^ (~e & g)) + KT[t] + w[t];
      y = (rr(a, 2) ^ rr(a, 13) ^ rr(a, 22)) + ((a & b) ^ (a & c) ^ (b & c));
      h = g; g = f; f = e; e = d + x; d = c; c = b; b = a; a = x + y;
    end
    return {st[255:224] + a, st[223:192] + b, st[191:160] + c, st[159:128] + d,
            st[127:96] + e, st[95:64] + f, st[63:32] + g, st[31:0] + h};
  endfunction

  function automatic logic [255:0] refDouble(input logic [255:0] m, input logic [511:0] b,
                                             input logic [31:0] n);
    logic [511:0] b2;
    logic [255:0] dg;
    b2 = b;
    b2[415:384] = n;
    dg = refCompress(m, b2);
    return refCompress(IV, {dg, 32'h8000_0000, 192'b0, 32'd256});
  endfunction

  function automatic logic [511:0] makeBlock(input int seed);
    logic [511:0] r;
    for (int i = 0; i < 16; i++)
      r[511-32*i -: 32] = (32'h9e3779b9 * 32'(i + 1 + seed)) ^ 32'h5bd1e995;
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runSearch(input logic [255:0] m, input logic [511:0] b,
                           input logic [255:0] t, input bit meddle,
                           output int cyc, output bit dropped);
    @(negedge clk);
    midIn = m; blkIn = b; tgtIn = t; start = 1'b1;
    @(posedge clk);
    cyc = 1;
    @(negedge clk);
    start = 1'b0;
    dropped = !done;
    while (!done && cyc < 6000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (meddle && cyc == 50) begin
        start = 1'b1;
        tgtIn = '0;
        blkIn = makeBlock(777);
        midIn = ~m;
      end else begin
        start = 1'b0;
      end
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(done == 1'b0, "R9 done after reset", 256'(done), 256'd0);
    check(found == 1'b0, "R9 found after reset", 256'(found), 256'd0);
    repeat (5) @(negedge clk);
    check(done == 1'b0 && found == 1'b0, "R9 idle stays quiet", 256'({done, found}), 256'd0);
  endtask

  task automatic testRefSanity();
    logic [255:0] got;
    got = refCompress(IV, {32'h61626380, 448'b0, 32'h0000_0018});
    check(got == 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad,
          "R2 reference model vector", got,
          256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad);
  endtask

  task automatic testEasyHit();
    logic [255:0] m, expH;
    logic [511:0] b;
    logic [31:0]  hashBefore;
    int cyc; bit dr;
    m = refCompress(IV, makeBlock(50));
    b = makeBlock(1);
    b[415:384] = 32'h1234_5678;
    expH = refDouble(m, b, 32'h1234_5678);
    runSearch(m, b, {256{1'b1}}, 1'b0, cyc, dr);
    check(done && found, "R5 hit flags", 256'({done, found}), 256'd3);
    check(nonce == 32'h1234_5678, "R1 first nonce from word 3", 256'(nonce), 256'h1234_5678);
    check(hash == expH, "R2 double hash value", hash, expH);
    check(cyc == 134, "R7 single attempt latency", 256'(cyc), 256'd134);
    hashBefore = hash[31:0];
    repeat (6) @(negedge clk);
    check(done && found && nonce == 32'h1234_5678 && hash[31:0] == hashBefore,
          "R5 outputs hold while done", 256'(nonce), 256'h1234_5678);
  endtask

  task automatic testFewSteps(input bit meddle, input string tag);
    logic [255:0] m, hv [8];
    logic [511:0] b;
    logic [31:0]  s;
    int j, cyc; bit dr;
    m = refCompress(IV, makeBlock(60));
    b = makeBlock(2);
    j = 0; s = 0;
    for (int k = 0; k < 32; k++) begin
      s = 32'h0000_1000 + 32'(8 * k);
      for (int i = 0; i < 8; i++) hv[i] = refDouble(m, b, s + 32'(i));
      j = 0;
      for (int i = 1; i < 8; i++) if (hv[i] < hv[j]) j = i;
      if (j >= 2) break;
    end
    b[415:384] = s;
    runSearch(m, b, hv[j] + 256'd1, meddle, cyc, dr);
    check(done && found, {tag, " hit flags"}, 256'({done, found}), 256'd3);
    check(nonce == s + 32'(j), {tag, " winning nonce"}, 256'(nonce), 256'(s + 32'(j)));
    check(hash == hv[j], {tag, " winning hash"}, hash, hv[j]);
    check(cyc == 134 * (j + 1), {tag, " latency"}, 256'(cyc), 256'(134 * (j + 1)));
    check(dr, "R10 restart drops done", 256'(!dr), 256'd0);
  endtask

  task automatic testEqualTarget();
    logic [255:0] m, h0, hi, expH;
    logic [511:0] b;
    logic [31:0]  s;
    int w, cyc; bit dr;
    m = refCompress(IV, makeBlock(70));
    b = makeBlock(3);
    w = 0; s = 0; h0 = '0; expH = '0;
    for (int k = 0; k < 16 && w == 0; k++) begin
      s = 32'h00AB_0000 + 32'(32 * k);
      h0 = refDouble(m, b, s);
      for (int i = 1; i < 16; i++) begin
        hi = refDouble(m, b, s + 32'(i));
        if (hi < h0) begin
          w = i; expH = hi;
          break;
        end
      end
    end
    b[415:384] = s;
    runSearch(m, b, h0, 1'b0, cyc, dr);
    check(nonce == s + 32'(w), "R3 equal hash rejected, nonce", 256'(nonce), 256'(s + 32'(w)));
    check(hash == expH && found, "R3 equal hash rejected, hash", hash, expH);
    check(cyc == 134 * (w + 1), "R4 retries counted", 256'(cyc), 256'(134 * (w + 1)));
  endtask

  task automatic testWrap();
    logic [255:0] m;
    logic [511:0] b;
    int cyc; bit dr;
    m = refCompress(IV, makeBlock(80));
    b = makeBlock(4);
    b[415:384] = 32'hFFFF_FFFF;
    runSearch(m, b, '0, 1'b0, cyc, dr);
    check(done && !found, "R6 exhausted flags", 256'({done, found}), 256'd2);
    check(nonce == 32'hFFFF_FFFF, "R6 exhausted nonce", 256'(nonce), 256'hFFFF_FFFF);
    check(hash == refDouble(m, b, 32'hFFFF_FFFF), "R2 hash of last candidate", hash,
          refDouble(m, b, 32'hFFFF_FFFF));
    check(cyc == 135, "R7 exhaustion latency", 256'(cyc), 256'd135);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRefSanity();
    testEasyHit();
    testFewSteps(1'b0, "R4 search past start");
    testFewSteps(1'b1, "R8 start and inputs ignored while busy");
    testEqualTarget();
    testWrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule